// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit single-precision operands over a fixed number of clock cycles. Each operand word carries a sign, a biased exponent and a fraction with an implied leading one. The unit compares the two magnitudes and shifts the smaller operand's significand right until both exponents match. It then adds or subtracts the significands according to the signs and the requested operation, and renormalises the result. Bits that fall off the low end are dropped, so the result is truncated toward zero.

A client offers a pair of operands and an operation select with `in_valid` while `in_ready` is high. The unit accepts them on that edge and ignores its inputs while it is busy. It raises `done` for one cycle when the result is ready and holds `result` until the next result replaces it. Normal numbers and zero are handled. An operand whose exponent field is zero counts as zero. A result that would need an exponent of zero or below is flushed to zero.

Top module: `fp32_addsub_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `in_ready` is 1, `done` is 0 and `result` is 0x00000000.
- R2: An operand pair is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from that edge until `done` rises. `done` is high for exactly the one cycle that follows the third rising edge after the accepting edge, and `in_ready` is 1 in that cycle. Inputs offered while `in_ready` is 0 have no effect on the result.
- R3: Operand encoding: bit 31 is the sign (0 positive, 1 negative), bits 30:23 are an exponent biased by 127, and bits 22:0 are the fraction. The value is ±1.fraction × 2^(exponent−127). An operand with exponent field 0 is treated as zero, whatever its fraction.
- R4: `op_sub` = 0 computes opa + opb. `op_sub` = 1 computes opa − opb, by inverting the sign of opb before the signed significand operation.
- R5: The operand with the smaller magnitude has its 24-bit significand shifted right by the exponent difference, and the shifted-out bits are discarded. A difference of 25 or more makes it contribute nothing.
- R6: The provisional exponent is the larger operand's exponent. The sign of a nonzero result is the sign of the larger-magnitude operand, taken after the inversion of R4.
- R7: If the significand sum carries out of 24 bits, it is shifted right by one and the exponent is incremented. The dropped low bit is lost.
- R8: If the significand sum has leading zeros, it is shifted left until the hidden one is in place, and the exponent is decremented once per shift.
- R9: An exact zero sum gives 0x00000000 (positive sign). So does a renormalised exponent of 0 or less.
- R10: `result` does not change except in the cycle where `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Unit idle, offer will be accepted |
| op_sub | input | 1 | 0 = add, 1 = subtract opb from opa |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | 32 | Truncated sum or difference |

## Verification
Several properties are checked on every cycle:
- the handshake: `in_ready` falls after acceptance, `done` is a single-cycle pulse while idle, and `result` is stable between pulses;
- the exponent increment on a significand carry;
- that a nonzero result takes the larger operand's sign;
- that a zero or underflowed result is exactly all zeros.

The numerical value can only be shown by the bench's scenarios. These cover the alignment truncation at differences of 24 and beyond, cancellation with long left shifts, flush to zero, and operands offered while busy. The bench compares each result against hand-computed words and against its own integer model of the four-step sequence.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int LZ_W   = $clog2(SIG_W + 1);

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } opnd_t;

  // Split a word; a zero exponent field yields a zero significand.
  function automatic opnd_t unpack_op(input logic [WORD_W-1:0] w, input logic flip);
    opnd_t o;
    o.sgn = w[WORD_W-1] ^ flip;
    o.exp = w[WORD_W-2 -: EXP_W];
    o.sig = (o.exp == '0) ? '0 : {1'b1, w[FRAC_W-1:0]};
    return o;
  endfunction

  // Magnitude order: exponent first, then significand.
  function automatic logic mag_ge(input opnd_t x, input opnd_t y);
    return {x.exp, x.sig} >= {y.exp, y.sig};
  endfunction

  // Leading zeros of a significand; SIG_W when it is all zero.
  function automatic logic [LZ_W-1:0] lead_zeros(input logic [SIG_W-1:0] v);
    int n;
    n = SIG_W;
    for (int i = 0; i < SIG_W; i++) begin
      if (v[i]) n = SIG_W - 1 - i;
    end
    return n[LZ_W-1:0];
  endfunction
endpackage

// File: rtl/fpa_align.sv
module fpa_align
  import fpa_pkg::*;
(
  input  opnd_t            x,
  input  opnd_t            y,
  output opnd_t            big,
  output logic [SIG_W-1:0] small_sh,
  output logic             eff_sub
);
  logic             swap;
  logic [EXP_W-1:0] small_exp;
  logic [SIG_W-1:0] small_sig;
  logic [EXP_W-1:0] gap;

  always_comb begin
    swap      = !mag_ge(x, y);
    big       = swap ? y : x;
    small_exp = swap ? x.exp : y.exp;
    small_sig = swap ? x.sig : y.sig;
    gap       = big.exp - small_exp;
    small_sh  = (gap > EXP_W'(SIG_W)) ? '0 : (small_sig >> gap);
    eff_sub   = x.sgn ^ y.sgn;
  end
endmodule

// File: rtl/fpa_sum.sv
module fpa_sum
  import fpa_pkg::*;
(
  input  logic [SIG_W-1:0] big_sig,
  input  logic [SIG_W-1:0] small_sig,
  input  logic             eff_sub,
  output logic [SIG_W:0]   total
);
  always_comb begin
    if (eff_sub) total = {1'b0, big_sig} - {1'b0, small_sig};
    else         total = {1'b0, big_sig} + {1'b0, small_sig};
  end
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm
  import fpa_pkg::*;
(
  input  logic              sgn,
  input  logic [EXP_W-1:0]  exp,
  input  logic [SIG_W:0]    total,
  output logic [WORD_W-1:0] res,
  output logic              carry,
  output logic              zero
);
  logic [LZ_W-1:0]   lz;
  logic [EXP_W+1:0]  ext_exp;
  logic [EXP_W+1:0]  ext_lz;
  logic [FRAC_W-1:0] frac_l;

  always_comb begin
    carry   = total[SIG_W];
    lz      = lead_zeros(total[SIG_W-1:0]);
    ext_exp = (EXP_W+2)'(exp);
    ext_lz  = (EXP_W+2)'(lz);
    frac_l  = FRAC_W'(total[SIG_W-1:0] << lz);
    zero    = 1'b0;
    if (total == '0) begin
      zero = 1'b1;
      res  = '0;
    end else if (carry) begin
      res = {sgn, exp + EXP_W'(1), total[SIG_W-1:1]};
    end else if (ext_exp <= ext_lz) begin
      zero = 1'b1;
      res  = '0;
    end else begin
      res = {sgn, exp - EXP_W'(lz), frac_l};
    end
  end
endmodule

// File: rtl/fp32_addsub_unit.sv
module fp32_addsub_unit
  import fpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              op_sub,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  typedef enum logic [1:0] {ST_IDLE, ST_ALIGN, ST_SUM, ST_NORM} state_t;

  state_t            state_q;
  opnd_t             x_q, y_q, big_q, big_d;
  logic [SIG_W-1:0]  bsig_unused_guard;
  logic [SIG_W-1:0]  ssh_d, ssh_q;
  logic              effsub_d, effsub_q;
  logic [SIG_W:0]    total_d, total_q;
  logic [WORD_W-1:0] res_d, result_q;
  logic              done_q;

  // Named events for the checker.
  logic             accept, fire_norm, norm_carry, norm_zero, big_sgn;
  logic [EXP_W-1:0] big_exp;

  assign accept    = in_valid && (state_q == ST_IDLE);
  assign fire_norm = (state_q == ST_NORM);
  assign big_sgn   = big_q.sgn;
  assign big_exp   = big_q.exp;
  assign bsig_unused_guard = big_q.sig;

  fpa_align u_align (
    .x(x_q), .y(y_q), .big(big_d), .small_sh(ssh_d), .eff_sub(effsub_d)
  );

  fpa_sum u_sum (
    .big_sig(bsig_unused_guard), .small_sig(ssh_q), .eff_sub(effsub_q), .total(total_d)
  );

  fpa_norm u_norm (
    .sgn(big_q.sgn), .exp(big_q.exp), .total(total_q),
    .res(res_d), .carry(norm_carry), .zero(norm_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      x_q      <= '0;
      y_q      <= '0;
      big_q    <= '0;
      ssh_q    <= '0;
      effsub_q <= 1'b0;
      total_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          x_q     <= unpack_op(opa, 1'b0);
          y_q     <= unpack_op(opb, op_sub);
          state_q <= ST_ALIGN;
        end
        ST_ALIGN: begin
          big_q    <= big_d;
          ssh_q    <= ssh_d;
          effsub_q <= effsub_d;
          state_q  <= ST_SUM;
        end
        ST_SUM: begin
          total_q <= total_d;
          state_q <= ST_NORM;
        end
        ST_NORM: begin
          result_q <= res_d;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready = (state_q == ST_IDLE);
  assign done     = done_q;
  assign result   = result_q;
endmodule

// File: rtl/fpa_checker.sv
module fpa_checker
  import fpa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              accept,
  input logic              done,
  input logic [WORD_W-1:0] result,
  input logic              fire_norm,
  input logic              norm_carry,
  input logic              norm_zero,
  input logic              big_sgn,
  input logic [EXP_W-1:0]  big_exp
);
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  p_carry_bumps_exp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_norm && norm_carry && !norm_zero) |=> (result[WORD_W-2 -: EXP_W] == $past(big_exp) + EXP_W'(1)));

  p_sign_from_larger_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_norm && !norm_zero) |=> (result[WORD_W-1] == $past(big_sgn)));

  p_zero_is_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_norm && norm_zero) |=> (result == '0));

  p_result_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind fp32_addsub_unit fpa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .accept(accept),
  .done(done), .result(result), .fire_norm(fire_norm),
  .norm_carry(norm_carry), .norm_zero(norm_zero),
  .big_sgn(big_sgn), .big_exp(big_exp)
);

// File: tb/sim_fp32_addsub_unit.sv
module sim_fp32_addsub_unit;
  localparam time CLK_PERIOD = 10;
  localparam int  NVEC = 17;
  localparam int  NRND = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        op_sub = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        in_ready, done;
  logic [31:0] result;
  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  fp32_addsub_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .opa(opa), .opb(opb), .done(done), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {op_sub, opa, opb, expected}
  localparam logic [96:0] VEC [NVEC] = '{
    {1'b0, 32'h3F800000, 32'h3F800000, 32'h40000000},
    {1'b1, 32'h3F800000, 32'h3F800000, 32'h00000000},
    {1'b1, 32'h40000000, 32'h3F800000, 32'h3F800000},
    {1'b0, 32'h3FC00000, 32'h40200000, 32'h40800000},
    {1'b0, 32'h3F800000, 32'hC0400000, 32'hC0000000},
    {1'b1, 32'h3F800000, 32'h40400000, 32'hC0000000},
    {1'b0, 32'h00000000, 32'h40A00000, 32'h40A00000},
    {1'b0, 32'h3F800000, 32'h30800000, 32'h3F800000},
    {1'b0, 32'h3F800000, 32'h33800000, 32'h3F800000},
    {1'b1, 32'h3F800001, 32'h3F800000, 32'h34000000},
    {1'b0, 32'h80000000, 32'h00000000, 32'h00000000},
    {1'b0, 32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFF},
    {1'b0, 32'h3F800000, 32'h3F800001, 32'h40000000},
    {1'b1, 32'h00800001, 32'h00800000, 32'h00000000},
    {1'b0, 32'h00000001, 32'h3F800000, 32'h3F800000},
    {1'b0, 32'h3F800000, 32'h3F400001, 32'h3FE00000},
    {1'b1, 32'h3FC00000, 32'h3F800000, 32'h3F000000}
  };
  localparam string VTAG [NVEC] = '{
    "R7 1+1", "R9 1-1", "R4 2-1", "R7 1.5+2.5", "R6 1+(-3)", "R6 R4 1-3",
    "R3 zero+5", "R5 gap30", "R5 gap24", "R8 cancel", "R9 -0+0",
    "R7 carry max", "R7 carry drop lsb", "R9 flush", "R3 exp0 as zero",
    "R5 align drop", "R8 half"
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Independent integer restatement of the four steps.
  function automatic logic [31:0] fp_model(input logic sub, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ka, kb, mb, ms, m;
    int ea, eb, sga, sgb, eg, es, d, e, sg;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    sa = (ea == 0) ? 0 : (longint'(a[22:0]) + 64'd8388608);
    sb = (eb == 0) ? 0 : (longint'(b[22:0]) + 64'd8388608);
    sga = int'(a[31]); sgb = int'(b[31] ^ sub);
    ka = longint'(ea) * 16777216 + sa;
    kb = longint'(eb) * 16777216 + sb;
    if (ka >= kb) begin eg = ea; es = eb; mb = sa; ms = sb; sg = sga; end
    else          begin eg = eb; es = ea; mb = sb; ms = sa; sg = sgb; end
    d = eg - es;
    ms = (d >= 40) ? 0 : ms / (longint'(1) <<< d);
    m = (sga == sgb) ? mb + ms : mb - ms;
    if (m == 0) return 32'h0;
    e = eg;
    while (m >= 16777216) begin m = m / 2; e++; end
    while (m < 8388608) begin m = m * 2; e--; end
    if (e <= 0) return 32'h0;
    return {sg[0], e[7:0], m[22:0]};
  endfunction

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Offer one operation; junk != 0 keeps offering other operands while busy.
  task automatic run_op(input logic sub, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] expv, input string tag, input bit junk);
    @(negedge clk);
    op_sub = sub; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 busy after accept", 32'(in_ready), 32'h0);
    if (junk) begin opa = ~a; opb = 32'h3F800000; op_sub = ~sub; end
    else in_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R2 no early done", 32'(done), 32'h0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R2 no early done", 32'(done), 32'h0);
    @(negedge clk);
    chk(done == 1'b1 && in_ready == 1'b1, "R2 done latency", 32'(done), 32'h1);
    chk(result == expv, tag, result, expv);
    @(negedge clk);
    chk(done == 1'b0 && result == expv, "R10 result held", result, expv);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && done == 1'b0 && result == 32'h0, "R1 in reset", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && done == 1'b0 && result == 32'h0, "R1 after reset", result, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i][96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], VTAG[i], 1'b0);
    end

    // R2: offers made while busy must not disturb the accepted pair.
    run_op(1'b0, 32'h3FC00000, 32'h40200000, 32'h40800000, "R2 busy inputs ignored", 1'b1);

    for (int i = 0; i < NRND; i++) begin
      logic [31:0] a, b;
      logic        s;
      seed = lcg(seed); a = {seed[31], 8'(100 + (seed[30:8] % 51)), 23'h0};
      seed = lcg(seed); a[22:0] = seed[22:0];
      seed = lcg(seed); b = {seed[31], 8'(100 + (seed[30:8] % 51)), 23'h0};
      if (i % 4 == 0) b[30:23] = a[30:23];
      seed = lcg(seed); b[22:0] = seed[22:0]; s = seed[31];
      run_op(s, a, b, fp_model(s, a, b), "R5 R6 R8 model", 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule